// File: doc/BRIEF.md
# Knob Pickup Parameter Matrix

This block holds a grid of control values: four menu pages, each with four values, one per knob. A pushbutton steps through the pages, and four knob readings arriving from an external converter update the values of the visible page. The outputs carry the current page number, the four values of that page, and a one-cycle strobe. The strobe tells the display and sound control logic that something has changed.

Changing pages would normally make every value jump to wherever the knobs happen to sit. To prevent this, each knob has a hold flag. The flag is raised on every page change and keeps the stored value frozen. It drops once the knob reading comes within a small window of the stored value. After that the knob writes every new reading. The button is synchronised, and each press opens a lockout that swallows contact bounce.

Top module: `pm_matrix`

## Requirements
- R1: After reset the page is 0, every stored value is 0, every hold flag is clear and `upd` is low, so readings are written straight away.
- R2: A rising edge of the synchronised button advances the page by one, and page 3 steps to page 0. A button held high or a falling edge does not step.
- R3: After an accepted rising edge, further rising edges are ignored for `LOCK_CYCLES` clocks (1 ms by default).
- R4: A page step raises the hold flag of every knob. The new page shows the values last stored in it, and a held knob's far reading leaves them unchanged.
- R5: A held knob whose reading differs from the stored value of the current page by at most `WINDOW` LSBs clears its flag, and that reading is stored. `WINDOW` is 81 at the defaults: 20 per mille of 4096, rounded down. A difference of `WINDOW`+1 is ignored.
- R6: A knob with a clear flag stores every reading it receives.
- R7: `upd` is high for exactly one cycle, in the first cycle that shows a new page or a newly stored value. `upd` stays low when a reading is ignored.
- R8: A reading that arrives in the same cycle as a page step is discarded.
- R9: `smp_knob` (0 to 3) selects the only value that a reading may change. The value of knob k appears on `act_vals[k*12 +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw | input | 1 | Unsynchronised menu pushbutton, high when pressed |
| smp_valid | input | 1 | A knob reading is present this cycle |
| smp_knob | input | 2 | Index of the knob the reading belongs to |
| smp_data | input | 12 | Knob reading, unsigned full scale |
| menu_state | output | 2 | Current menu page |
| act_vals | output | 48 | Four values of the current page, knob 0 in the low bits |
| upd | output | 1 | One-cycle strobe on any page change or stored value |

## Verification
The hardest case to reach is a knob reading that lands in exactly the cycle a page step takes effect. The step appears only after the two synchroniser stages. The bench therefore counts falling clock edges from the moment it raises the button and presents the reading on the cycle the edge detector fires. A follow-up far reading then shows that the flag stayed raised. Bounce is produced by toggling the button within the lockout. The button is then held past the lockout to show that no edge is invented. Window limits are probed at exactly `WINDOW` and `WINDOW`+1 in both directions.

// File: rtl/pm_pkg.sv
// Package: shared defaults for the knob pickup parameter matrix.
// Assumes: all users derive widths from these values or from overrides.
package pm_pkg;
    localparam int PM_DATA_W      = 12;
    localparam int PM_STATES      = 4;
    localparam int PM_KNOBS       = 4;
    localparam int PM_WIN_PERMILL = 20;
    localparam int PM_LOCK_CYCLES = 125000;
endpackage

// File: rtl/pm_btn_step.sv
// Module: pm_btn_step
// Synchronises the raw button and emits a one-cycle step on each rising
// edge. After an accepted edge it ignores edges for LOCK_CYCLES clocks.
// Assumes: btn_i is asynchronous to clk; LOCK_CYCLES >= 1.
module pm_btn_step #(
    parameter int LOCK_CYCLES = pm_pkg::PM_LOCK_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic step_o
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

    logic             s1_q, s2_q, prev_q;
    logic [CNT_W-1:0] lock_q;
    logic             rise;

    // Two-stage synchroniser plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= btn_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign rise   = s2_q && !prev_q;
    assign step_o = rise && (lock_q == '0);

    // Lockout counter: loaded on an accepted edge, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              lock_q <= '0;
        else if (step_o)         lock_q <= CNT_LOAD;
        else if (lock_q != '0)   lock_q <= lock_q - 1'b1;
    end

    // R3: two accepted edges can never follow one another directly.
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);
endmodule

// File: rtl/pm_knob_cell.sv
// Module: pm_knob_cell
// Stores one knob's value for every menu page and the knob's hold flag.
// A held knob is released when a reading falls within WINDOW of the stored
// value of the current page.
// Assumes: state_i < NUM_STATES; step_i and smp_en_i come from the same clock.
module pm_knob_cell #(
    parameter int DATA_W     = pm_pkg::PM_DATA_W,
    parameter int NUM_STATES = pm_pkg::PM_STATES,
    parameter int WINDOW     = 81,
    localparam int ST_W      = $clog2(NUM_STATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [ST_W-1:0]   state_i,
    input  logic              smp_en_i,
    input  logic [DATA_W-1:0] smp_data_i,
    output logic [DATA_W-1:0] act_o,
    output logic              wr_o
);
    localparam logic [DATA_W-1:0] WIN_L = DATA_W'(WINDOW);

    logic [DATA_W-1:0] vals_q [NUM_STATES];
    logic              hold_q;
    logic [DATA_W-1:0] diff;
    logic              near;

    assign act_o = vals_q[state_i];

    // Absolute distance between the reading and the stored value.
    always_comb begin
        if (smp_data_i >= act_o) diff = smp_data_i - act_o;
        else                     diff = act_o - smp_data_i;
        near = (diff <= WIN_L);
    end

    assign wr_o = smp_en_i && !step_i && (!hold_q || near);

    // Page storage and hold flag: a step freezes, an accepted reading writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STATES; s++) vals_q[s] <= '0;
            hold_q <= 1'b0;
        end else if (step_i) begin
            hold_q <= 1'b1;
        end else if (wr_o) begin
            vals_q[state_i] <= smp_data_i;
            hold_q          <= 1'b0;
        end
    end

    // R4: every page step leaves the flag raised.
    a_r4_hold_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> hold_q);
    // R5: a near reading on a held knob releases it.
    a_r5_pickup_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && smp_en_i && !step_i && near) |=> !hold_q);
    // R4: a held knob with no near reading keeps the shown value.
    a_r4_frozen_value: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !step_i && !(smp_en_i && near)) |=> $stable(act_o));
endmodule

// File: rtl/pm_matrix.sv
// Module: pm_matrix (top)
// Menu parameter matrix with knob pickup: pages stepped by a button, one
// storage cell per knob, and a registered update strobe.
// Assumes: smp_knob < NUM_KNOBS whenever smp_valid is high.
module pm_matrix #(
    parameter int DATA_W      = pm_pkg::PM_DATA_W,
    parameter int NUM_STATES  = pm_pkg::PM_STATES,
    parameter int NUM_KNOBS   = pm_pkg::PM_KNOBS,
    parameter int WIN_PERMILL = pm_pkg::PM_WIN_PERMILL,
    parameter int LOCK_CYCLES = pm_pkg::PM_LOCK_CYCLES,
    localparam int ST_W       = $clog2(NUM_STATES),
    localparam int KI_W       = $clog2(NUM_KNOBS),
    localparam int WINDOW     = ((1 << DATA_W) * WIN_PERMILL) / 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        btn_raw,
    input  logic                        smp_valid,
    input  logic [KI_W-1:0]             smp_knob,
    input  logic [DATA_W-1:0]           smp_data,
    output logic [ST_W-1:0]             menu_state,
    output logic [NUM_KNOBS*DATA_W-1:0] act_vals,
    output logic                        upd
);
    localparam logic [ST_W-1:0] LAST_ST = ST_W'(NUM_STATES - 1);

    logic                 step;
    logic [ST_W-1:0]      state_q;
    logic [NUM_KNOBS-1:0] wr;
    logic                 upd_q;

    pm_btn_step #(.LOCK_CYCLES(LOCK_CYCLES)) u_btn (
        .clk    (clk),
        .rst_n  (rst_n),
        .btn_i  (btn_raw),
        .step_o (step)
    );

    // Menu page counter with wrap to page 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                 state_q <= '0;
        else if (step && state_q == LAST_ST) state_q <= '0;
        else if (step)              state_q <= state_q + 1'b1;
    end

    for (genvar k = 0; k < NUM_KNOBS; k++) begin : g_knob
        pm_knob_cell #(
            .DATA_W     (DATA_W),
            .NUM_STATES (NUM_STATES),
            .WINDOW     (WINDOW)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_i     (step),
            .state_i    (state_q),
            .smp_en_i   (smp_valid && (smp_knob == KI_W'(k))),
            .smp_data_i (smp_data),
            .act_o      (act_vals[k*DATA_W +: DATA_W]),
            .wr_o       (wr[k])
        );
    end

    // Update strobe, aligned with the first cycle showing the change.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= step || (|wr);
    end

    assign menu_state = state_q;
    assign upd        = upd_q;

    // R2: the last page steps to page 0.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && state_q == LAST_ST) |=> (state_q == '0));
    // R7: any page change is announced in the same cycle.
    a_r7_strobe_on_page: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> upd);
    // R9: a reading enables at most one cell.
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));
endmodule

// File: tb/pm_matrix_tb.sv
// Scoreboard bench: driver tasks update a reference model and push the
// expected snapshot; a monitor pops one entry per update strobe.
module pm_matrix_tb;
    localparam int DW   = 12;
    localparam int LOCK = 50;
    localparam int WIN  = (4096 * 20) / 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          btn_raw = 1'b0;
    logic          smp_valid = 1'b0;
    logic [1:0]    smp_knob = '0;
    logic [DW-1:0] smp_data = '0;
    logic [1:0]    menu_state;
    logic [47:0]   act_vals;
    logic          upd;

    int checks = 0;
    int fails  = 0;

    logic [49:0] exp_q [$];
    int          mvals [4][4];
    bit          mhold [4];
    int          mstate;

    always #4 clk = ~clk;

    pm_matrix #(.LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .smp_valid(smp_valid),
        .smp_knob(smp_knob), .smp_data(smp_data), .menu_state(menu_state),
        .act_vals(act_vals), .upd(upd)
    );

    function automatic logic [49:0] snap();
        logic [49:0] v;
        v[49:48] = 2'(mstate);
        for (int k = 0; k < 4; k++) v[k*DW +: DW] = DW'(mvals[mstate][k]);
        return v;
    endfunction

    task automatic model_step();
        mstate = (mstate + 1) % 4;
        for (int k = 0; k < 4; k++) mhold[k] = 1'b1;
        exp_q.push_back(snap());
    endtask

    // Drive one reading; the model decides whether it is stored.
    task automatic sample(input int k, input int d);
        int ad;
        ad = d - mvals[mstate][k];
        if (ad < 0) ad = -ad;
        if (!mhold[k] || ad <= WIN) begin
            mvals[mstate][k] = d;
            mhold[k] = 1'b0;
            exp_q.push_back(snap());
        end
        @(negedge clk);
        smp_valid = 1'b1; smp_knob = 2'(k); smp_data = DW'(d);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic press();
        model_step();
        @(negedge clk); btn_raw = 1'b1;
        repeat (6) @(negedge clk); btn_raw = 1'b0;
        repeat (LOCK + 10) @(negedge clk);
    endtask

    task automatic check_now(input string req);
        checks++;
        if (menu_state != 2'(mstate) || act_vals != snap()[47:0] || exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s state/vals actual=%0d/%h expected=%0d/%h pending=%0d",
                     req, menu_state, act_vals, mstate, snap()[47:0], exp_q.size());
        end
    endtask

    // Monitor: compare each update against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && upd) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R7 unexpected update actual=%h expected=none",
                         {menu_state, act_vals});
            end else begin
                logic [49:0] e;
                e = exp_q.pop_front();
                if ({menu_state, act_vals} != e) begin
                    fails++;
                    $display("FAIL R7 update content actual=%h expected=%h",
                             {menu_state, act_vals}, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        mstate = 0;
        for (int s = 0; s < 4; s++) for (int k = 0; k < 4; k++) mvals[s][k] = 0;
        for (int k = 0; k < 4; k++) mhold[k] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (upd !== 1'b0) begin
            fails++;
            $display("FAIL R1 upd actual=%b expected=0", upd);
        end
        check_now("R1");

        // R6/R9: free knobs store every reading, only the addressed one.
        sample(0, 1000); sample(1, 4095); sample(2, 5); sample(3, 2000);
        sample(2, 7);
        check_now("R6");

        // R4: page 1 starts at zero, held.
        press();
        check_now("R4");
        sample(0, 3000);
        check_now("R4");
        // R5: window limits.
        sample(0, WIN);
        check_now("R5");
        sample(0, WIN + 1);
        check_now("R6");
        sample(1, WIN + 1);
        check_now("R5");
        sample(1, WIN);
        check_now("R5");

        // R3: bounce yields one step only; held button makes no extra edge.
        model_step();
        @(negedge clk); btn_raw = 1'b1;
        repeat (3) @(negedge clk); btn_raw = 1'b0;
        repeat (3) @(negedge clk); btn_raw = 1'b1;
        repeat (LOCK + 20) @(negedge clk);
        check_now("R3");
        btn_raw = 1'b0;
        repeat (LOCK + 10) @(negedge clk);
        check_now("R3");

        // R2: page 2 -> 3 -> 0, page 0 keeps its values.
        press();
        check_now("R2");
        press();
        check_now("R2");
        check_now("R4");
        sample(0, 1000 + WIN + 1);
        check_now("R4");
        sample(0, 1000 - WIN);
        check_now("R5");

        // R8: reading in the step cycle is discarded.
        model_step();
        @(negedge clk); btn_raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b1; smp_knob = 2'd2; smp_data = DW'(3);
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (4) @(negedge clk); btn_raw = 1'b0;
        repeat (LOCK + 10) @(negedge clk);
        check_now("R8");
        sample(2, 200);
        check_now("R8");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule